// File: doc/BRIEF.md
# Data Address Watchpoint and Relocation Checker

This block sits on the data-address path of a load/store unit and inspects every access in the cycle it is presented. It first relocates low addresses into the current process slot. The top seven address bits are filled from a process-ID word when those bits of the incoming address are all zero and the process-ID field is nonzero. The relocated address is then tested for word alignment when the alignment check is switched on, and compared against two watchpoint address registers under a debug-control word.

The result of each access appears one clock after the access strobe, all from registers. It holds the relocated address and an alignment-abort request together with the fault status and fault address to record. It also holds a watchpoint-hit request and the debug-status word with the entry-reason field filled in. The register storage and the exception vectoring belong to the surrounding core. The block only reads the register contents on its inputs and reports what should be recorded.

Top module: `dag_addr_guard`

## Requirements
- R1: When `pid_reg[31:25]` is nonzero and `acc_addr[31:25]` is zero, `out_addr` equals `acc_addr` with `pid_reg[31:25]` placed in bits 31:25.
- R2: When either `pid_reg[31:25]` is zero or `acc_addr[31:25]` is nonzero, `out_addr` equals `acc_addr` unchanged.
- R3: When `ctl_reg[1]` is set and the relocated address has a nonzero bit in 1:0, `align_abort` is raised, `fault_status` is 32'h0000_0008 and `fault_addr` is the relocated address. Otherwise `align_abort` is low and `fault_status` is zero.
- R4: Each watchpoint enable field is 2 bits: 0 disables the comparator, 1 matches stores only, 2 matches stores and loads, 3 matches loads only (`acc_store` = 1 marks a store).
- R5: With `dbg_ctl[8]` clear, comparator 0 (enable `dbg_ctl[1:0]`) hits when relocated address bits 31:2 equal `bkpt_addr0[31:2]`. Comparator 1 (enable `dbg_ctl[3:2]`) does the same against `bkpt_addr1`. Either one raises `bkpt_hit`.
- R6: With `dbg_ctl[8]` set, only comparator 0 is used. Bits set in `bkpt_addr1` are excluded from the compare of the relocated address against `bkpt_addr0`, including bits 1:0, and `dbg_ctl[3:2]` has no effect.
- R7: When `dbg_stat_i[31]` is set, `bkpt_hit` stays low whatever the addresses and enables.
- R8: `dbg_stat_o` equals `dbg_stat_i` except that, on a hit, bits 4:2 carry the data-watchpoint entry code 3'b010.
- R9: An access that raises `align_abort` never raises `bkpt_hit`, and its `dbg_stat_o` is left unmodified.
- R10: All results appear exactly one clock after the clock edge that samples `acc_valid`. A cycle without `acc_valid` gives `out_valid`, `align_abort` and `bkpt_hit` low in the following cycle.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Incoming data address |
| pid_reg | input | 32 | Process-ID word, field in bits 31:25 |
| ctl_reg | input | 32 | Control word, bit 1 enables alignment check |
| dbg_ctl | input | 32 | Watchpoint enables (1:0, 3:2) and mask mode (8) |
| dbg_stat_i | input | 32 | Debug-status word, bit 31 suppresses watchpoints |
| bkpt_addr0 | input | 32 | Watchpoint address 0 |
| bkpt_addr1 | input | 32 | Watchpoint address 1 or inverse mask |
| out_valid | output | 1 | Registered access strobe |
| out_addr | output | 32 | Relocated address |
| align_abort | output | 1 | Data-abort request for a misaligned access |
| fault_status | output | 32 | Fault status to record |
| fault_addr | output | 32 | Fault address to record |
| bkpt_hit | output | 1 | Watchpoint hit request |
| dbg_stat_o | output | 32 | Debug-status word to write back |

## Verification
An alignment abort and a watchpoint match can fall on the same access. The bench provokes this with accesses whose relocated address matches an enabled watchpoint while a low address bit is set and alignment checking is on, both in directed cases and in random traffic where the watchpoint registers are often reused as addresses. Such an access is judged correct only when the abort request is raised with its fault record, the hit request stays low and the returned debug-status word is unchanged.

// File: rtl/dag_pkg.sv
package dag_pkg;

  // Watchpoint enable field encoding
  typedef enum logic [1:0] {
    WP_OFF   = 2'd0,
    WP_STORE = 2'd1,
    WP_BOTH  = 2'd2,
    WP_LOAD  = 2'd3
  } wp_en_e;

  // Whether an access of the given kind may match under an enable code
  function automatic logic wp_kind_ok(input logic [1:0] code, input logic is_store);
    logic ok;
    unique case (wp_en_e'(code))
      WP_OFF:   ok = 1'b0;
      WP_STORE: ok = is_store;
      WP_BOTH:  ok = 1'b1;
      WP_LOAD:  ok = ~is_store;
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dag_relocate.sv
module dag_relocate #(
  parameter int ADDR_W  = 32,
  parameter int PID_LSB = 25
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pid_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int FLD_W = ADDR_W - PID_LSB;

  logic [FLD_W-1:0] pid_fld;
  logic [FLD_W-1:0] addr_fld;
  logic             do_reloc;
  logic             unused_pid;

  assign pid_fld    = pid_i[ADDR_W-1:PID_LSB];
  assign addr_fld   = addr_i[ADDR_W-1:PID_LSB];
  assign unused_pid = ^pid_i[PID_LSB-1:0];

  always_comb begin
    do_reloc = (pid_fld != '0) && (addr_fld == '0);
    addr_o   = addr_i;
    if (do_reloc) begin
      addr_o[ADDR_W-1:PID_LSB] = pid_fld;
    end
  end
endmodule

// File: rtl/dag_align_chk.sv
module dag_align_chk #(
  parameter int ADDR_W    = 32,
  parameter int CTL_W     = 32,
  parameter int GRAN_LSBS = 2,
  parameter int EN_BIT    = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic              misalign_o
);
  logic check_on;
  logic unused_align;

  assign check_on     = ctl_i[EN_BIT];
  assign unused_align = ^{addr_i[ADDR_W-1:GRAN_LSBS], ctl_i};

  always_comb begin
    misalign_o = check_on && (addr_i[GRAN_LSBS-1:0] != '0);
  end
endmodule

// File: rtl/dag_wp_unit.sv
module dag_wp_unit
  import dag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTL_W     = 32,
  parameter int NUM_CMP   = 2,
  parameter int EN_W      = 2,
  parameter int IGN_LSBS  = 2,
  parameter int MASK_BIT  = 8
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      store_i,
  input  logic [CTL_W-1:0]          ctl_i,
  input  logic [NUM_CMP*ADDR_W-1:0] wp_regs_i,
  output logic                      hit_o
);
  localparam int CMP_W = ADDR_W - IGN_LSBS;

  logic [NUM_CMP-1:0] kind_ok;
  logic [NUM_CMP-1:0] exact_hit;
  logic [ADDR_W-1:0]  wp0;
  logic [ADDR_W-1:0]  inv_mask;
  logic               mask_mode;
  logic               masked_hit;
  logic               unused_ctl;

  assign unused_ctl = ^ctl_i;

  // One comparator per watchpoint register, each with its own enable field
  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    logic [ADDR_W-1:0] wp_reg;
    logic [EN_W-1:0]   en_code;
    assign wp_reg  = wp_regs_i[gi*ADDR_W +: ADDR_W];
    assign en_code = ctl_i[gi*EN_W +: EN_W];
    always_comb begin
      kind_ok[gi]   = wp_kind_ok(en_code, store_i);
      exact_hit[gi] = kind_ok[gi] &&
                      (addr_i[ADDR_W-1 -: CMP_W] == wp_reg[ADDR_W-1 -: CMP_W]);
    end
  end

  // Mask mode: register 1 excludes bits from the compare against register 0
  assign wp0       = wp_regs_i[0 +: ADDR_W];
  assign inv_mask  = wp_regs_i[ADDR_W +: ADDR_W];
  assign mask_mode = ctl_i[MASK_BIT];

  always_comb begin
    masked_hit = kind_ok[0] && (((addr_i ^ wp0) & ~inv_mask) == '0);
    if (mask_mode) begin
      hit_o = masked_hit;
    end else begin
      hit_o = |exact_hit;
    end
  end
endmodule

// File: rtl/dag_addr_guard.sv
module dag_addr_guard #(
  parameter int              ADDR_W     = 32,
  parameter int              CTL_W      = 32,
  parameter int              PID_LSB    = 25,
  parameter int              ALIGN_BIT  = 1,
  parameter int              MASK_BIT   = 8,
  parameter int              GDE_BIT    = 31,
  parameter int              MOE_LSB    = 2,
  parameter int              MOE_W      = 3,
  parameter logic [2:0]      MOE_CODE   = 3'b010,
  parameter logic [31:0]     FAULT_CODE = 32'h0000_0008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] pid_reg,
  input  logic [CTL_W-1:0]  ctl_reg,
  input  logic [CTL_W-1:0]  dbg_ctl,
  input  logic [CTL_W-1:0]  dbg_stat_i,
  input  logic [ADDR_W-1:0] bkpt_addr0,
  input  logic [ADDR_W-1:0] bkpt_addr1,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              align_abort,
  output logic [CTL_W-1:0]  fault_status,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              bkpt_hit,
  output logic [CTL_W-1:0]  dbg_stat_o
);
  localparam int NUM_CMP   = 2;
  localparam int EN_W      = 2;
  localparam int GRAN_LSBS = 2;

  logic [ADDR_W-1:0] reloc_addr;
  logic              misalign;
  logic              raw_hit;
  logic              wp_blocked;
  logic              hit_take;

  logic              valid_d, valid_q;
  logic              abort_d, abort_q;
  logic              hit_d,   hit_q;
  logic [ADDR_W-1:0] addr_d,  addr_q;
  logic [ADDR_W-1:0] faddr_d, faddr_q;
  logic [CTL_W-1:0]  fstat_d, fstat_q;
  logic [CTL_W-1:0]  dstat_d, dstat_q;
  logic              data_en;

  dag_relocate #(
    .ADDR_W  (ADDR_W),
    .PID_LSB (PID_LSB)
  ) u_relocate (
    .addr_i (acc_addr),
    .pid_i  (pid_reg),
    .addr_o (reloc_addr)
  );

  dag_align_chk #(
    .ADDR_W    (ADDR_W),
    .CTL_W     (CTL_W),
    .GRAN_LSBS (GRAN_LSBS),
    .EN_BIT    (ALIGN_BIT)
  ) u_align (
    .addr_i     (reloc_addr),
    .ctl_i      (ctl_reg),
    .misalign_o (misalign)
  );

  dag_wp_unit #(
    .ADDR_W   (ADDR_W),
    .CTL_W    (CTL_W),
    .NUM_CMP  (NUM_CMP),
    .EN_W     (EN_W),
    .IGN_LSBS (GRAN_LSBS),
    .MASK_BIT (MASK_BIT)
  ) u_wp (
    .addr_i    (reloc_addr),
    .store_i   (acc_store),
    .ctl_i     (dbg_ctl),
    .wp_regs_i ({bkpt_addr1, bkpt_addr0}),
    .hit_o     (raw_hit)
  );

  // Next-state: alignment abort outranks the watchpoint, debug enable gates it
  always_comb begin
    wp_blocked = dbg_stat_i[GDE_BIT];
    hit_take   = raw_hit && !wp_blocked && !misalign;
    data_en    = acc_valid;

    valid_d = acc_valid;
    abort_d = acc_valid && misalign;
    hit_d   = acc_valid && hit_take;
    addr_d  = reloc_addr;
    faddr_d = reloc_addr;
    fstat_d = misalign ? FAULT_CODE : '0;
    dstat_d = dbg_stat_i;
    if (hit_take) begin
      dstat_d[MOE_LSB +: MOE_W] = MOE_CODE;
    end
  end

  // Flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      abort_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      abort_q <= abort_d;
      hit_q   <= hit_d;
    end
  end

  // Data registers, loaded only on an access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      faddr_q <= '0;
      fstat_q <= '0;
      dstat_q <= '0;
    end else if (data_en) begin
      addr_q  <= addr_d;
      faddr_q <= faddr_d;
      fstat_q <= fstat_d;
      dstat_q <= dstat_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_addr     = addr_q;
  assign align_abort  = abort_q;
  assign fault_status = fstat_q;
  assign fault_addr   = faddr_q;
  assign bkpt_hit     = hit_q;
  assign dbg_stat_o   = dstat_q;
endmodule

// File: rtl/dag_guard_chk.sv
module dag_guard_chk #(
  parameter int          ADDR_W     = 32,
  parameter int          CTL_W      = 32,
  parameter int          PID_LSB    = 25,
  parameter int          GDE_BIT    = 31,
  parameter int          MOE_LSB    = 2,
  parameter int          MOE_W      = 3,
  parameter logic [2:0]  MOE_CODE   = 3'b010,
  parameter logic [31:0] FAULT_CODE = 32'h0000_0008
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W-1:0] pid_reg,
  input logic [CTL_W-1:0]  dbg_stat_i,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              align_abort,
  input logic [CTL_W-1:0]  fault_status,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              bkpt_hit,
  input logic [CTL_W-1:0]  dbg_stat_o
);
  logic past_ok;
  logic unused_chk;

  assign unused_chk = ^{acc_addr, pid_reg, dbg_stat_i, out_addr, fault_addr, dbg_stat_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_valid && !align_abort && !bkpt_hit && out_addr == '0);
    end
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(acc_valid)));

  // R9
  abort_over_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(align_abort && bkpt_hit));

  // R7
  gde_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && bkpt_hit) |-> !$past(dbg_stat_i[GDE_BIT]));

  // R3
  abort_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_abort |-> (fault_addr[1:0] != 2'b00 && fault_status == FAULT_CODE && out_valid));

  // R8
  moe_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_hit |-> (dbg_stat_o[MOE_LSB +: MOE_W] == MOE_CODE));

  // R1
  reloc_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(acc_valid && pid_reg[ADDR_W-1:PID_LSB] != '0 &&
                      acc_addr[ADDR_W-1:PID_LSB] == '0))
    |-> (out_addr[ADDR_W-1:PID_LSB] == $past(pid_reg[ADDR_W-1:PID_LSB])));
endmodule

bind dag_addr_guard dag_guard_chk #(
  .ADDR_W     (ADDR_W),
  .CTL_W      (CTL_W),
  .PID_LSB    (PID_LSB),
  .GDE_BIT    (GDE_BIT),
  .MOE_LSB    (MOE_LSB),
  .MOE_W      (MOE_W),
  .MOE_CODE   (MOE_CODE),
  .FAULT_CODE (FAULT_CODE)
) u_guard_chk (.*);

// File: tb/test_dag_addr_guard.sv
module test_dag_addr_guard;
  logic        clk;
  logic        rst_n;
  logic        acc_valid, acc_store;
  logic [31:0] acc_addr, pid_reg, ctl_reg, dbg_ctl, dbg_stat_i, bkpt_addr0, bkpt_addr1;
  logic        out_valid, align_abort, bkpt_hit;
  logic [31:0] out_addr, fault_status, fault_addr, dbg_stat_o;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [31:0] FCODE = 32'h0000_0008;

  dag_addr_guard i_dag_addr_guard (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_addr(acc_addr), .pid_reg(pid_reg), .ctl_reg(ctl_reg), .dbg_ctl(dbg_ctl),
    .dbg_stat_i(dbg_stat_i), .bkpt_addr0(bkpt_addr0), .bkpt_addr1(bkpt_addr1),
    .out_valid(out_valid), .out_addr(out_addr), .align_abort(align_abort),
    .fault_status(fault_status), .fault_addr(fault_addr), .bkpt_hit(bkpt_hit),
    .dbg_stat_o(dbg_stat_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] m_reloc(input logic [31:0] a, input logic [31:0] p);
    if (p[31:25] != 7'd0 && a[31:25] == 7'd0) return {p[31:25], a[24:0]};
    return a;
  endfunction

  function automatic logic m_en(input logic [1:0] f, input logic st);
    if (f == 2'd0) return 1'b0;
    if (st) return f != 2'd3;
    return f != 2'd1;
  endfunction

  function automatic logic m_hit(input logic [31:0] r, input logic st, input logic [31:0] dc,
                                 input logic [31:0] ds, input logic [31:0] b0, input logic [31:0] b1);
    if (ds[31]) return 1'b0;
    if (dc[8]) return m_en(dc[1:0], st) && ((r & ~b1) == (b0 & ~b1));
    return (m_en(dc[1:0], st) && r[31:2] == b0[31:2]) ||
           (m_en(dc[3:2], st) && r[31:2] == b1[31:2]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one access at a falling edge and check results at the next falling edge
  task automatic access(input logic st, input logic [31:0] a, input logic [31:0] p,
                        input logic [31:0] c, input logic [31:0] dc, input logic [31:0] ds,
                        input logic [31:0] b0, input logic [31:0] b1, input string htag);
    logic [31:0] er;
    logic        eab, ehit;
    logic [31:0] estat;
    acc_valid = 1'b1; acc_store = st; acc_addr = a; pid_reg = p; ctl_reg = c;
    dbg_ctl = dc; dbg_stat_i = ds; bkpt_addr0 = b0; bkpt_addr1 = b1;
    er    = m_reloc(a, p);
    eab   = c[1] && (er[1:0] != 2'b00);
    ehit  = m_hit(er, st, dc, ds, b0, b1) && !eab;
    estat = ehit ? {ds[31:5], 3'b010, ds[1:0]} : ds;
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 out_valid", {31'd0, out_valid}, 32'd1);
    chk(out_addr == er, (er == a) ? "R2 out_addr" : "R1 out_addr", out_addr, er);
    chk(align_abort == eab, "R3 align_abort", {31'd0, align_abort}, {31'd0, eab});
    chk(fault_status == (eab ? FCODE : 32'd0), "R3 fault_status", fault_status, eab ? FCODE : 32'd0);
    if (eab) chk(fault_addr == er, "R3 fault_addr", fault_addr, er);
    chk(bkpt_hit == ehit, htag, {31'd0, bkpt_hit}, {31'd0, ehit});
    chk(dbg_stat_o == estat, "R8 dbg_stat_o", dbg_stat_o, estat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] w0, w1, a, p, c, dc, ds;
    logic        st;
    string       tg;
    void'($urandom(32'd4242));
    rst_n = 1'b0; acc_valid = 1'b0; acc_store = 1'b0; acc_addr = '0; pid_reg = '0;
    ctl_reg = '0; dbg_ctl = '0; dbg_stat_i = '0; bkpt_addr0 = '0; bkpt_addr1 = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!out_valid && !align_abort && !bkpt_hit, "R11 flags in reset", {29'd0, out_valid, align_abort, bkpt_hit}, 32'd0);
    chk(out_addr == 0 && dbg_stat_o == 0 && fault_status == 0 && fault_addr == 0, "R11 data in reset", out_addr, 32'd0);
    rst_n = 1'b1;

    // R4 enable encodings, comparator 0 and comparator 1
    for (int code = 0; code < 4; code++) begin
      for (int s = 0; s < 2; s++) begin
        access(s[0], 32'h4000_1002, 0, 0, code, 0, 32'h4000_1000, 32'h7000_0000, "R4 cmp0 enable");
        access(s[0], 32'h7000_0003, 0, 0, code << 2, 0, 32'h4000_1000, 32'h7000_0000, "R4 cmp1 enable");
      end
    end
    // R5 bit 2 differs: no hit
    access(1'b1, 32'h4000_1004, 0, 0, 32'h2, 0, 32'h4000_1000, 32'h7000_0000, "R5 bit2 mismatch");
    // R6 mask mode: masked low byte matches, unmasked bit does not, cmp1 ignored
    access(1'b0, 32'h1234_56AB, 0, 0, 32'h102, 0, 32'h1234_5678, 32'h0000_00FF, "R6 masked match");
    access(1'b0, 32'h1235_5678, 0, 0, 32'h102, 0, 32'h1234_5678, 32'h0000_00FF, "R6 unmasked differ");
    access(1'b0, 32'h0000_00FC, 0, 0, 32'h10C, 0, 32'h1234_5678, 32'h0000_00FF, "R6 cmp1 ignored");
    // R7 global debug enable blocks hit
    access(1'b1, 32'h4000_1000, 0, 0, 32'h2, 32'h8000_0000, 32'h4000_1000, 0, "R7 blocked hit");
    // R1 relocation, R2 no relocation
    access(1'b0, 32'h0000_1230, 32'hAE00_0000, 0, 0, 0, 0, 0, "R1 reloc no wp");
    access(1'b0, 32'h0200_1230, 32'hAE00_0000, 0, 0, 0, 0, 0, "R2 top bits set");
    // R9 abort and hit on the same access; relocated compare
    access(1'b1, 32'h0000_4001, 32'h5E00_0000, 32'h2, 32'h2, 32'h0000_0013, 32'h5E00_4000, 0, "R9 abort over hit");
    access(1'b1, 32'h0000_4000, 32'h5E00_0000, 32'h2, 32'h2, 32'h0000_0013, 32'h5E00_4000, 0, "R5 relocated hit");

    // Random traffic
    for (int i = 0; i < 800; i++) begin
      w0 = $urandom; w1 = $urandom;
      p  = ($urandom % 2) ? 32'd0 : $urandom;
      case ($urandom % 4)
        0: a = w0 ^ ($urandom % 4);
        1: a = w1 ^ ($urandom % 8);
        2: a = {7'd0, $urandom(), 25'd0} | ($urandom & 32'h01FF_FFFF);
        default: a = $urandom;
      endcase
      c  = $urandom;
      dc = $urandom & 32'h0000_010F;
      ds = ($urandom % 4 == 0) ? ($urandom | 32'h8000_0000) : ($urandom & 32'h7FFF_FFFF);
      st = $urandom;
      if (ds[31]) tg = "R7 hit random";
      else if (c[1] && m_reloc(a, p) % 4 != 0) tg = "R9 hit random";
      else if (dc[8]) tg = "R6 hit random";
      else tg = "R5 hit random";
      access(st, a, p, c, dc, ds, w0, w1, tg);
      if (i % 50 == 49) begin
        acc_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid && !align_abort && !bkpt_hit, "R10 idle cycle",
            {29'd0, out_valid, align_abort, bkpt_hit}, 32'd0);
      end
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule